// File: doc/BRIEF.md
# Run-Length Sample Packet Formatter

This block turns a stream of logic-analyzer samples into run-length records and serializes them as bytes. Consecutive equal samples merge into one record made of the sample value and a repeat count. When the value changes, or the count field would overflow, the open run is closed. Records are grouped five to a transfer unit. Each unit ends with a rolling sequence byte. The byte stream leaves through a valid/ready handshake. When the consumer stalls, the sample input is held off through its own ready signal, so no sample is dropped.

Two pulse inputs mark points in the stream. A trigger pulse closes the open run, so the trigger lands exactly on a record boundary. The block also freezes a count of the records that came before that boundary. A flush pulse closes the open run and pads the unit in progress with empty records. After a flush, the stream ends on a whole unit. Three 32-bit counters are readable at all times: records emitted, records before the trigger, and bytes delivered. A receiver uses them to size its download and to place the trigger.

Top module: `rle_xfer_packer`

## Requirements
- R1: Every record is three bytes on the output: sample bits [7:0] first, then sample bits [15:8], then the 8-bit repeat count. Record bytes sit at unit byte offsets 0..14.
- R2: A transfer unit is 16 bytes: five records followed by one sequence byte at unit offset 15.
- R3: Consecutive equal accepted samples extend the open run. A sample that differs from the open run's value closes that run as one record with its count, and the new sample opens a new run with count 1.
- R4: A run never counts more than 255. The 256th equal sample closes a record of count 255 and opens a new run of the same value, so 600 equal samples give counts 255, 255, 90.
- R5: The sequence byte is 0 in the first unit after reset. It rises by one per unit and wraps from 255 to 0.
- R6: A flush closes the open run, if there is one. It then appends records of value 0 and count 0 until the current unit is complete. A flush at a unit boundary with no open run adds nothing.
- R7: A trigger closes the open run. Until the first trigger after reset, the pre-trigger count equals the total record count. At the first trigger it freezes at the number of records emitted up to and including the run it closed. Later triggers do not change it.
- R8: The total record count includes padding records. It is a multiple of five once a flush has been fully emitted.
- R9: The write position equals the number of bytes accepted on the output (valid and ready high at a clock edge) since reset.
- R10: While output valid is high and ready is low, the output byte stays unchanged. Once internal storage is full, sample ready drops, and every sample accepted is represented in the stream.
- R11: After reset: output valid is low, all three counters are 0, and sample ready is high.
- R12: Trigger and flush pulses that arrive while sample ready is low are held and acted on later, not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample present |
| smp_data | input | 16 | Sample value |
| smp_ready | output | 1 | Sample accepted at the edge when valid is also high |
| trig_hit | input | 1 | One-cycle trigger pulse |
| flush_req | input | 1 | One-cycle flush pulse |
| byte_valid | output | 1 | Output byte present |
| byte_data | output | 8 | Output byte |
| byte_ready | input | 1 | Consumer takes the byte at this edge |
| rec_total | output | 32 | Records emitted since reset |
| rec_pretrig | output | 32 | Records before the first trigger |
| wr_bytes | output | 32 | Bytes delivered since reset |

## Verification
Latency is counted from the edge where a run-closing sample is accepted:
- The record enters the builder's output register at that edge.
- The serializer loads it at the next edge, and the counters update on that same edge.
- Its first byte appears one edge later, and the remaining bytes follow one per accepted output cycle.

A trigger or flush pulse is first latched as pending, which adds one edge before the run closes. Because output stalls stretch every one of these delays, the bench does not check fixed cycle counts. It instead compares the whole byte sequence, position by position, against an arithmetic model. It samples the counters only after a drain of 60 cycles with ready held high, which covers the longest backlog of a record, up to four padding records and a sequence byte.

// File: rtl/rle_pkg.sv
package rle_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic pad;
    logic trig;
  } rle_mark_t;
endpackage

// File: rtl/rle_run_builder.sv
module rle_run_builder #(
  parameter int SAMPLE_W = 16,
  parameter int RUN_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                in_ready,
  input  logic                trig_pulse,
  input  logic                flush_pulse,
  output logic                rec_valid,
  input  logic                rec_ready,
  output logic [SAMPLE_W-1:0] rec_val,
  output logic [RUN_W-1:0]    rec_cnt,
  output rle_pkg::rle_mark_t  rec_mark
);
  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [SAMPLE_W-1:0] run_val;
  logic [RUN_W-1:0]    run_cnt;
  logic                trig_p;
  logic                flush_p;
  logic                go;
  logic                take_evt;
  logic                take_smp;
  logic                extend;
  logic                close_s;

  assign go       = !rec_valid || rec_ready;
  assign take_evt = go && (trig_p || flush_p);
  assign in_ready = go && !trig_p && !flush_p;
  assign take_smp = in_valid && in_ready;
  assign extend   = (run_cnt != '0) && (in_data == run_val) && (run_cnt != RUN_MAX);
  assign close_s  = take_smp && (run_cnt != '0) && !extend;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_val   <= '0;
      run_cnt   <= '0;
      trig_p    <= 1'b0;
      flush_p   <= 1'b0;
      rec_valid <= 1'b0;
      rec_val   <= '0;
      rec_cnt   <= '0;
      rec_mark  <= '0;
    end else begin
      trig_p  <= (trig_p && !take_evt) || trig_pulse;
      flush_p <= (flush_p && !take_evt) || flush_pulse;
      if (take_evt) begin
        rec_valid     <= 1'b1;
        rec_val       <= run_val;
        rec_cnt       <= run_cnt;
        rec_mark.pad  <= flush_p;
        rec_mark.trig <= trig_p;
        run_cnt       <= '0;
      end else if (take_smp) begin
        if (close_s) begin
          rec_valid <= 1'b1;
          rec_val   <= run_val;
          rec_cnt   <= run_cnt;
          rec_mark  <= '0;
        end else if (rec_ready) begin
          rec_valid <= 1'b0;
        end
        run_val <= in_data;
        run_cnt <= extend ? run_cnt + 1'b1 : RUN_W'(1);
      end else if (rec_ready) begin
        rec_valid <= 1'b0;
      end
    end
  end

  // R10
  rec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_val) && $stable(rec_cnt));

  // R3
  rec_marker_chk: assert property (@(posedge clk) disable iff (rst)
    rec_valid && (rec_cnt == '0) |-> rec_mark.pad || rec_mark.trig);
endmodule

// File: rtl/rle_unit_serializer.sv
module rle_unit_serializer #(
  parameter int SAMPLE_W      = 16,
  parameter int RUN_W         = 8,
  parameter int RECS_PER_UNIT = 5,
  parameter int SEQ_W         = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rec_valid,
  output logic                         rec_ready,
  input  logic [SAMPLE_W-1:0]          rec_val,
  input  logic [RUN_W-1:0]             rec_cnt,
  input  rle_pkg::rle_mark_t           rec_mark,
  output logic                         out_valid,
  output logic [rle_pkg::BYTE_W-1:0]   out_data,
  input  logic                         out_ready,
  output logic                         rec_loaded,
  output logic                         trig_seen_now,
  output logic                         byte_sent
);
  localparam int REC_W     = SAMPLE_W + RUN_W;
  localparam int REC_BYTES = REC_W / rle_pkg::BYTE_W;
  localparam int BIDX_W    = (REC_BYTES > 1) ? $clog2(REC_BYTES) : 1;
  localparam int SLOT_W    = (RECS_PER_UNIT > 1) ? $clog2(RECS_PER_UNIT) : 1;
  localparam logic [BIDX_W-1:0] BIDX_LAST = BIDX_W'(REC_BYTES - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(RECS_PER_UNIT - 1);

  logic [REC_W-1:0]  hold_q;
  logic              hold_v;
  logic [BIDX_W-1:0] bidx;
  logic [SLOT_W-1:0] slot;
  logic [SEQ_W-1:0]  seq_q;
  logic              seq_pend;
  logic              pad_pend;
  logic              push;
  logic              take;
  logic              pad_idle;
  logic              pad_load;

  assign rec_ready     = !hold_v && !seq_pend && !pad_pend;
  assign take          = rec_valid && rec_ready;
  assign pad_idle      = !hold_v && !seq_pend && pad_pend;
  assign pad_load      = pad_idle && (slot != '0);
  assign push          = !out_valid || out_ready;
  assign rec_loaded    = (take && (rec_cnt != '0)) || pad_load;
  assign trig_seen_now = take && rec_mark.trig;
  assign byte_sent     = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      hold_v    <= 1'b0;
      bidx      <= '0;
      slot      <= '0;
      seq_q     <= '0;
      seq_pend  <= 1'b0;
      pad_pend  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (push) begin
        if (seq_pend) begin
          out_valid <= 1'b1;
          out_data  <= rle_pkg::BYTE_W'(seq_q);
          seq_q     <= seq_q + 1'b1;
          seq_pend  <= 1'b0;
        end else if (hold_v) begin
          out_valid <= 1'b1;
          out_data  <= hold_q[{bidx, 3'b000} +: rle_pkg::BYTE_W];
          if (bidx == BIDX_LAST) begin
            bidx   <= '0;
            hold_v <= 1'b0;
            if (slot == SLOT_LAST) begin
              slot     <= '0;
              seq_pend <= 1'b1;
            end else begin
              slot <= slot + 1'b1;
            end
          end else begin
            bidx <= bidx + 1'b1;
          end
        end else begin
          out_valid <= 1'b0;
        end
      end
      if (take) begin
        if (rec_cnt != '0) begin
          hold_q <= {rec_cnt, rec_val};
          hold_v <= 1'b1;
        end
        if (rec_mark.pad) pad_pend <= 1'b1;
      end else if (pad_load) begin
        hold_q <= '0;
        hold_v <= 1'b1;
      end else if (pad_idle) begin
        pad_pend <= 1'b0;
      end
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    slot <= SLOT_LAST);

  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    seq_q != $past(seq_q) |-> seq_q == $past(seq_q) + 1'b1);
endmodule

// File: rtl/rle_tally.sv
module rle_tally #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rec_loaded,
  input  logic             trig_seen_now,
  input  logic             byte_sent,
  output logic [CNT_W-1:0] total_q,
  output logic [CNT_W-1:0] pre_q,
  output logic [CNT_W-1:0] wpos_q
);
  logic             trig_seen;
  logic [CNT_W-1:0] total_nx;

  assign total_nx = total_q + CNT_W'(rec_loaded);

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q   <= '0;
      pre_q     <= '0;
      wpos_q    <= '0;
      trig_seen <= 1'b0;
    end else begin
      total_q <= total_nx;
      if (!trig_seen) pre_q <= total_nx;
      if (trig_seen_now) trig_seen <= 1'b1;
      if (byte_sent) wpos_q <= wpos_q + 1'b1;
    end
  end

  // R8
  total_step_chk: assert property (@(posedge clk) disable iff (rst)
    total_q == $past(total_q) || total_q == $past(total_q) + 1'b1);

  // R7
  pre_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    trig_seen |=> $stable(pre_q));

  // R9
  wpos_step_chk: assert property (@(posedge clk) disable iff (rst)
    wpos_q == $past(wpos_q) || wpos_q == $past(wpos_q) + 1'b1);
endmodule

// File: rtl/rle_xfer_packer.sv
module rle_xfer_packer #(
  parameter int SAMPLE_W      = 16,
  parameter int RUN_W         = 8,
  parameter int RECS_PER_UNIT = 5,
  parameter int SEQ_W         = 8,
  parameter int CNT_W         = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_valid,
  input  logic [SAMPLE_W-1:0]        smp_data,
  output logic                       smp_ready,
  input  logic                       trig_hit,
  input  logic                       flush_req,
  output logic                       byte_valid,
  output logic [rle_pkg::BYTE_W-1:0] byte_data,
  input  logic                       byte_ready,
  output logic [CNT_W-1:0]           rec_total,
  output logic [CNT_W-1:0]           rec_pretrig,
  output logic [CNT_W-1:0]           wr_bytes
);
  logic               r_valid;
  logic               r_ready;
  logic [SAMPLE_W-1:0] r_val;
  logic [RUN_W-1:0]   r_cnt;
  rle_pkg::rle_mark_t r_mark;
  logic               ld;
  logic               tg;
  logic               bs;

  rle_run_builder #(.SAMPLE_W(SAMPLE_W), .RUN_W(RUN_W)) u_build (
    .clk(clk), .rst(rst),
    .in_valid(smp_valid), .in_data(smp_data), .in_ready(smp_ready),
    .trig_pulse(trig_hit), .flush_pulse(flush_req),
    .rec_valid(r_valid), .rec_ready(r_ready),
    .rec_val(r_val), .rec_cnt(r_cnt), .rec_mark(r_mark)
  );

  rle_unit_serializer #(.SAMPLE_W(SAMPLE_W), .RUN_W(RUN_W),
                        .RECS_PER_UNIT(RECS_PER_UNIT), .SEQ_W(SEQ_W)) u_ser (
    .clk(clk), .rst(rst),
    .rec_valid(r_valid), .rec_ready(r_ready),
    .rec_val(r_val), .rec_cnt(r_cnt), .rec_mark(r_mark),
    .out_valid(byte_valid), .out_data(byte_data), .out_ready(byte_ready),
    .rec_loaded(ld), .trig_seen_now(tg), .byte_sent(bs)
  );

  rle_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst),
    .rec_loaded(ld), .trig_seen_now(tg), .byte_sent(bs),
    .total_q(rec_total), .pre_q(rec_pretrig), .wpos_q(wr_bytes)
  );
endmodule

// File: tb/sim_rle_xfer_packer.sv
`timescale 1ns/1ps
module sim_rle_xfer_packer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        smp_ready;
  logic        trig_hit = 1'b0;
  logic        flush_req = 1'b0;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic        byte_ready = 1'b0;
  logic [31:0] rec_total, rec_pretrig, wr_bytes;

  int checks = 0;
  int failures = 0;
  int rdy_mode = 0;
  int cyc = 0;
  int wd = 0;
  bit done = 0;

  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  logic [15:0] m_val;
  int m_cnt, m_total, m_slot, m_pre, m_bytes;
  logic [7:0] m_seq;
  bit m_trig;

  always #2 clk = ~clk;

  rle_xfer_packer u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .trig_hit(trig_hit), .flush_req(flush_req),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
    .rec_total(rec_total), .rec_pretrig(rec_pretrig), .wr_bytes(wr_bytes)
  );

  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      0: byte_ready = 1'b1;
      1: byte_ready = (cyc % 3 == 0);
      2: byte_ready = ((cyc % 12) < 5);
      default: byte_ready = 1'b0;
    endcase
    if (!rst && byte_valid && byte_ready) got_q.push_back(byte_data);
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", wd);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic m_rec(input logic [15:0] v, input int c);
    exp_q.push_back(v[7:0]);
    exp_q.push_back(v[15:8]);
    exp_q.push_back(8'(c));
    m_total++;
    m_bytes += 3;
    m_slot++;
    if (m_slot == 5) begin
      exp_q.push_back(m_seq);
      m_seq++;
      m_bytes++;
      m_slot = 0;
    end
  endtask

  task automatic m_clear();
    m_cnt = 0; m_total = 0; m_slot = 0; m_pre = 0; m_bytes = 0;
    m_seq = 8'd0; m_trig = 0; m_val = '0;
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic send(input logic [15:0] v);
    smp_valid = 1'b1;
    smp_data  = v;
    while (!smp_ready) @(negedge clk);
    @(negedge clk);
    smp_valid = 1'b0;
    if (m_cnt == 0) begin
      m_val = v; m_cnt = 1;
    end else if (v == m_val && m_cnt < 255) begin
      m_cnt++;
    end else begin
      m_rec(m_val, m_cnt);
      m_val = v; m_cnt = 1;
    end
  endtask

  task automatic pulse_trig();
    trig_hit = 1'b1;
    @(negedge clk);
    trig_hit = 1'b0;
    if (m_cnt > 0) m_rec(m_val, m_cnt);
    m_cnt = 0;
    if (!m_trig) begin
      m_trig = 1;
      m_pre = m_total;
    end
  endtask

  task automatic pulse_flush();
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    if (m_cnt > 0) m_rec(m_val, m_cnt);
    m_cnt = 0;
    while (m_slot != 0) m_rec(16'h0000, 0);
  endtask

  task automatic drain();
    rdy_mode = 0;
    repeat (60) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_clear();
    chk(!byte_valid, "R11", "byte_valid after reset", byte_valid, 0);
    chk(smp_ready, "R11", "smp_ready after reset", smp_ready, 1);
    chk(rec_total == 0 && rec_pretrig == 0 && wr_bytes == 0, "R11",
        "counters after reset", rec_total + rec_pretrig + wr_bytes, 0);
  endtask

  task automatic compare(input string scen);
    int n;
    chk(got_q.size() == exp_q.size(), "R2", {scen, " byte count"},
        got_q.size(), exp_q.size());
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++) begin
      int p;
      p = i % 16;
      if (p == 15)
        chk(got_q[i] == exp_q[i], "R5", {scen, " sequence byte"}, got_q[i], exp_q[i]);
      else if (p % 3 == 2)
        chk(got_q[i] == exp_q[i], "R4", {scen, " count byte"}, got_q[i], exp_q[i]);
      else
        chk(got_q[i] == exp_q[i], "R1", {scen, " value byte"}, got_q[i], exp_q[i]);
    end
    chk(rec_total == 32'(m_total), "R8", {scen, " total"}, rec_total, m_total);
    chk(rec_total % 5 == 0, "R8", {scen, " total multiple of 5"}, rec_total % 5, 0);
    chk(rec_pretrig == 32'(m_trig ? m_pre : m_total), "R7", {scen, " pretrig"},
        rec_pretrig, m_trig ? m_pre : m_total);
    chk(wr_bytes == 32'(m_bytes), "R9", {scen, " write position"}, wr_bytes, m_bytes);
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    int t0;
    logic [7:0] held;
    m_clear();
    @(negedge clk);
    do_reset();

    // S1: every sample distinct, flush pads 12 records to 15 (R3, R6)
    t0 = int'(rec_total);
    rdy_mode = 0;
    for (int i = 0; i < 12; i++) send(16'h0100 + 16'(i * 257));
    pulse_flush();
    drain();
    chk(int'(rec_total) - t0 == 15, "R6", "S1 padded record total", int'(rec_total) - t0, 15);
    compare("S1");

    // S2: merged runs and a 600-sample run split 255/255/90 (R3, R4)
    t0 = int'(rec_total);
    rdy_mode = 1;
    for (int i = 0; i < 7; i++) send(16'hA5A5);
    for (int i = 0; i < 3; i++) send(16'h0B0B);
    send(16'h00C3);
    for (int i = 0; i < 600; i++) send(16'hD00D);
    send(16'hE001);
    pulse_flush();
    drain();
    chk(int'(rec_total) - t0 == 10, "R3", "S2 record total", int'(rec_total) - t0, 10);
    compare("S2");

    // S3: stall output, trigger while sample ready low (R10, R12, R7)
    t0 = int'(rec_total);
    rdy_mode = 3;
    repeat (2) @(negedge clk);
    send(16'h1111);
    send(16'h2222);
    send(16'h3333);
    repeat (4) @(negedge clk);
    chk(!smp_ready, "R10", "smp_ready low under stall", smp_ready, 0);
    held = byte_data;
    repeat (5) @(negedge clk);
    chk(byte_valid && byte_data == held, "R10", "byte held under stall", byte_data, held);
    pulse_trig();
    repeat (3) @(negedge clk);
    rdy_mode = 2;
    for (int i = 0; i < 4; i++) send(16'h4000 + 16'(i));
    pulse_trig();
    send(16'h5555);
    pulse_flush();
    drain();
    chk(int'(rec_pretrig) == t0 + 3, "R12", "stalled trigger position",
        int'(rec_pretrig), t0 + 3);
    compare("S3");

    // S4: flush exactly at unit boundary, then an empty flush (R6)
    t0 = int'(rec_total);
    for (int i = 0; i < 5; i++) send(16'h7000 + 16'(i));
    pulse_flush();
    pulse_flush();
    drain();
    chk(int'(rec_total) - t0 == 5, "R6", "S4 no padding at boundary", int'(rec_total) - t0, 5);
    compare("S4");

    // S5: 1400 records, sequence byte wraps (R5)
    do_reset();
    rdy_mode = 2;
    for (int i = 0; i < 1400; i++) send((i % 2 == 0) ? 16'h0F0F : 16'hF0F0);
    pulse_flush();
    drain();
    chk(wr_bytes == 32'd4480, "R5", "S5 bytes for 280 units", wr_bytes, 4480);
    compare("S5");

    done = 1;
    report();
    $finish;
  end
endmodule